// File: doc/BRIEF.md
# Guarded Fractional Multiply-Accumulate Datapath

This block is the multiply-accumulate stage of a fixed-point signal-processing core. Each cycle with the valid strobe high it forms the signed product of two 16-bit operands and then does one of four things with it. It can clear the accumulator, load the accumulator with the product, add the product to the accumulator, or subtract the product from it. The accumulator is 40 bits wide. Its 8 guard bits above the 32-bit product range let long sums run without losing the sign.

The product can be taken as an integer, or as a fractional value. A fractional product is doubled, and the one case that cannot be represented is clamped to the largest positive value. A combinational result path reads the registered accumulator and returns a 16-bit word. It rounds either to nearest or convergently (ties to even), and it can optionally saturate when the guard bits hold more than a sign extension. A sticky flag records any wrap of the 40-bit sum.

Top module: `dsp_mac_unit`

## Requirements
- R1: After reset the accumulator is zero, the overflow flag is low and the 16-bit result is 0x0000.
- R2: With `frac_mode`=0, op_sel 2'b01 (multiply) loads the accumulator with the 32-bit signed product of `opa` and `opb`, sign-extended to 40 bits.
- R3: With `frac_mode`=1, the product is the signed product shifted left by one. The operand pair 0x8000 × 0x8000 gives 0x7FFF_FFFF instead.
- R4: op_sel 2'b10 (accumulate) adds the product to the accumulator, and op_sel 2'b11 (subtract) subtracts it. The new value is visible on `acc_out` one clock after the valid edge, and an operation can be issued on every cycle.
- R5: op_sel 2'b00 (clear) sets the accumulator to zero and clears the overflow flag.
- R6: While `in_valid` is low, the accumulator and the overflow flag keep their values whatever the other inputs are.
- R7: When an accumulate or subtract result does not fit in 40 signed bits, the accumulator wraps modulo 2^40 and `ovf_flag` rises. The flag then stays high through later operations until a clear.
- R8: With `round_conv`=0, `res_out` is bits [31:16] of the accumulator plus 0x8000.
- R9: With `round_conv`=1 and the low 16 accumulator bits exactly 0x8000, the result is rounded to the even neighbour. For any other low bits, the result is the same as in R8.
- R10: With `sat_en`=1, the result is clamped when bits [40:31] of the rounded 41-bit value are not all equal. It becomes 0x7FFF if the value is positive and 0x8000 if it is negative. With `sat_en`=0, the result is the raw bits [31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Performs the selected operation this cycle |
| op_sel | input | 2 | 00 clear, 01 multiply, 10 accumulate, 11 subtract |
| frac_mode | input | 1 | 1 fractional product, 0 integer product |
| round_conv | input | 1 | 1 convergent rounding, 0 round to nearest |
| sat_en | input | 1 | Enables saturation of the 16-bit result |
| opa | input | 16 | Signed operand A |
| opb | input | 16 | Signed operand B |
| acc_out | output | 40 | Registered accumulator |
| res_out | output | 16 | Rounded, optionally saturated result |
| ovf_flag | output | 1 | Sticky accumulator overflow flag |

## Verification
The accumulator is exposed directly on `acc_out`. A wrong product, a missed carry into the guard bits or a lost update therefore shows up one clock after the offending valid cycle. Because every later sum builds on the corrupted value, the error is never hidden afterwards. Rounding and saturation faults are combinational on the registered value, so they show on `res_out` in the same cycle as the accumulator they act on. A flag that is not sticky shows as `ovf_flag` falling on the first non-clear operation after a wrap.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_MPY = 2'b01,
    OP_MAC = 2'b10,
    OP_MSU = 2'b11
  } mac_op_e;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OPW = 16,
  localparam int PW = 2 * OPW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [OPW-1:0] a_i,
  input  logic signed [OPW-1:0] b_i,
  input  logic                  frac_i,
  output logic signed [PW-1:0]  prod_o,
  output logic                  corner_o
);

  localparam logic [OPW-1:0] OP_MIN  = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [PW-1:0]  PR_MAX  = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0]  PR_MIN  = {1'b1, {(PW-1){1'b0}}};

  function automatic logic signed [PW-1:0] form_product(
    input logic signed [OPW-1:0] x,
    input logic signed [OPW-1:0] y,
    input logic                  fr
  );
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    logic signed [PW-1:0] raw;
    xe  = {{OPW{x[OPW-1]}}, x};
    ye  = {{OPW{y[OPW-1]}}, y};
    raw = xe * ye;
    if (!fr) begin
      form_product = raw;
    end else if (x == OP_MIN && y == OP_MIN) begin
      form_product = PR_MAX;
    end else begin
      form_product = raw <<< 1;
    end
  endfunction

  assign corner_o = frac_i && (a_i == OP_MIN) && (b_i == OP_MIN);
  assign prod_o   = form_product(a_i, b_i, frac_i);

  // R3: a doubled product is always even unless clamped, and never the most negative value
  a_r3_frac_even: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i && !corner_o) |-> !prod_o[0]);
  a_r3_frac_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    frac_i |-> (prod_o != PR_MIN));

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import dsp_mac_pkg::*;
#(
  parameter int PW   = 32,
  parameter int ACCW = 40,
  localparam int GW  = ACCW - PW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  mac_op_e                op_i,
  input  logic signed [PW-1:0]   prod_i,
  output logic signed [ACCW-1:0] acc_q,
  output logic                   ovf_q,
  output logic                   wrap_evt
);

  logic signed [ACCW-1:0] prod_ext;
  logic        [ACCW:0]   sum_w;
  logic        [ACCW-1:0] acc_d;

  function automatic logic [ACCW:0] add_sub(
    input logic [ACCW-1:0] acc,
    input logic [ACCW-1:0] p,
    input logic            sub
  );
    logic [ACCW:0] ae;
    logic [ACCW:0] pe;
    ae = {acc[ACCW-1], acc};
    pe = {p[ACCW-1], p};
    add_sub = sub ? (ae - pe) : (ae + pe);
  endfunction

  assign prod_ext = {{GW{prod_i[PW-1]}}, prod_i};
  assign sum_w    = add_sub(acc_q, prod_ext, op_i == OP_MSU);
  assign wrap_evt = ((op_i == OP_MAC) || (op_i == OP_MSU)) && (sum_w[ACCW] != sum_w[ACCW-1]);

  always_comb begin
    case (op_i)
      OP_CLR:  acc_d = '0;
      OP_MPY:  acc_d = prod_ext;
      default: acc_d = sum_w[ACCW-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (valid_i) begin
      acc_q <= acc_d;
      if (op_i == OP_CLR)  ovf_q <= 1'b0;
      else if (wrap_evt)   ovf_q <= 1'b1;
    end
  end

  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_CLR) |=> (acc_q == '0 && !ovf_q));
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(acc_q) && $stable(ovf_q)));
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(valid_i && op_i == OP_CLR)) |=> ovf_q);
  a_r7_wrap_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wrap_evt) |=> ovf_q);
  // R2: a loaded product never occupies the guard bits beyond sign extension
  a_r2_load_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_MPY) |=> ((&acc_q[ACCW-1:PW-1]) || !(|acc_q[ACCW-1:PW-1])));

endmodule

// File: rtl/mac_round_sat.sv
module mac_round_sat #(
  parameter int ACCW  = 40,
  parameter int OPW   = 16,
  parameter int FRACB = 16,
  localparam int RW   = ACCW + 1,
  localparam int TOP  = FRACB + OPW - 1
) (
  input  logic [ACCW-1:0] acc_i,
  input  logic            conv_i,
  input  logic            sat_en_i,
  output logic [OPW-1:0]  res_o,
  output logic            tie_evt,
  output logic            sat_evt
);

  localparam logic [RW-1:0]  HALF  = RW'(1) << (FRACB - 1);
  localparam logic [OPW-1:0] R_MAX = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] R_MIN = {1'b1, {(OPW-1){1'b0}}};

  logic [RW-1:0]  rnd;
  logic [RW-TOP-1:0] hi_bits;

  function automatic logic [RW-1:0] round_acc(
    input logic [ACCW-1:0] a,
    input logic            conv
  );
    logic [RW-1:0] r;
    r = {a[ACCW-1], a} + HALF;
    if (conv && (a[FRACB-1:0] == HALF[FRACB-1:0])) r[FRACB] = 1'b0;
    round_acc = r;
  endfunction

  assign tie_evt = (acc_i[FRACB-1:0] == HALF[FRACB-1:0]);
  assign rnd     = round_acc(acc_i, conv_i);
  assign hi_bits = rnd[RW-1:TOP];
  assign sat_evt = !((&hi_bits) || !(|hi_bits));

  always_comb begin
    if (sat_en_i && sat_evt) res_o = rnd[RW-1] ? R_MIN : R_MAX;
    else                     res_o = rnd[TOP:FRACB];
  end

endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
  import dsp_mac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int GUARD = 8,
  localparam int PW   = 2 * OPW,
  localparam int ACCW = PW + GUARD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic            frac_mode,
  input  logic            round_conv,
  input  logic            sat_en,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  output logic [ACCW-1:0] acc_out,
  output logic [OPW-1:0]  res_out,
  output logic            ovf_flag
);

  logic signed [PW-1:0]   prod_w;
  logic                   corner_w;
  logic signed [ACCW-1:0] acc_w;
  logic                   wrap_w;
  logic                   tie_w;
  logic                   sat_w;
  mac_op_e                op_w;

  assign op_w = mac_op_e'(op_sel);

  mac_product #(.OPW(OPW)) u_prod (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (opa),
    .b_i      (opb),
    .frac_i   (frac_mode),
    .prod_o   (prod_w),
    .corner_o (corner_w)
  );

  mac_accum #(.PW(PW), .ACCW(ACCW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (in_valid),
    .op_i     (op_w),
    .prod_i   (prod_w),
    .acc_q    (acc_w),
    .ovf_q    (ovf_flag),
    .wrap_evt (wrap_w)
  );

  mac_round_sat #(.ACCW(ACCW), .OPW(OPW), .FRACB(OPW)) u_rnd (
    .acc_i    (acc_w),
    .conv_i   (round_conv),
    .sat_en_i (sat_en),
    .res_o    (res_out),
    .tie_evt  (tie_w),
    .sat_evt  (sat_w)
  );

  assign acc_out = acc_w;

  a_r10_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && sat_w) |-> (res_out == {1'b0, {(OPW-1){1'b1}}} || res_out == {1'b1, {(OPW-1){1'b0}}}));
  a_r9_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
    (round_conv && tie_w && !(sat_en && sat_w)) |-> !res_out[0]);
  a_r3_corner_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_w == OP_MPY && corner_w) |=> (acc_out == ACCW'({1'b0, {(PW-1){1'b1}}})));

endmodule

// File: tb/dsp_mac_unit_tb.sv
module dsp_mac_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  // {frac, a, b, expected accumulator}
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 16'h0003, 16'h0004, 40'h00_0000_000C},
    {1'b0, 16'hFFFE, 16'h0005, 40'hFF_FFFF_FFF6},
    {1'b0, 16'h7FFF, 16'h7FFF, 40'h00_3FFF_0001},
    {1'b0, 16'h8000, 16'h8000, 40'h00_4000_0000},
    {1'b0, 16'h8000, 16'h7FFF, 40'hFF_C000_8000},
    {1'b1, 16'h4000, 16'h4000, 40'h00_2000_0000},
    {1'b1, 16'h8000, 16'h8000, 40'h00_7FFF_FFFF},
    {1'b1, 16'h8000, 16'h4000, 40'hFF_C000_0000},
    {1'b1, 16'hFFFF, 16'h0001, 40'hFF_FFFF_FFFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        frac_mode = 1'b0;
  logic        round_conv = 1'b0;
  logic        sat_en = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [39:0] acc_out;
  logic [15:0] res_out;
  logic        ovf_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .frac_mode(frac_mode), .round_conv(round_conv), .sat_en(sat_en),
    .opa(opa), .opb(opb), .acc_out(acc_out), .res_out(res_out), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with the result registered
  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b, input logic fr);
    in_valid = 1'b1; op_sel = op; opa = a; opb = b; frac_mode = fr;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic chk_res(input string tag, input logic conv, input logic sat, input logic [15:0] exp);
    round_conv = conv; sat_en = sat;
    #1;
    chk(tag, {24'h0, res_out}, {24'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 acc reset", acc_out, 40'h0);
    chk("R1 ovf reset", {39'h0, ovf_flag}, 40'h0);
    chk("R1 res reset", {24'h0, res_out}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: product table
    for (int i = 0; i < NV; i++) begin
      issue(2'b01, VEC[i][71:56], VEC[i][55:40], VEC[i][72]);
      chk(VEC[i][72] ? "R3 frac product" : "R2 int product", acc_out, VEC[i][39:0]);
    end

    // R5 then R4: back-to-back accumulate / subtract
    issue(2'b00, 16'h0, 16'h0, 1'b0);
    chk("R5 clear", acc_out, 40'h0);
    issue(2'b10, 16'd100, 16'd200, 1'b0);
    chk("R4 mac add", acc_out, 40'd20000);
    issue(2'b10, 16'd3, 16'hFFF9, 1'b0);
    chk("R4 mac neg", acc_out, 40'd19979);
    issue(2'b11, 16'd10, 16'd10, 1'b0);
    chk("R4 msu", acc_out, 40'd19879);

    // R6: valid low, aggressive inputs
    in_valid = 1'b0; op_sel = 2'b00; opa = 16'h1234; opb = 16'h5678;
    @(negedge clk);
    op_sel = 2'b10;
    @(negedge clk);
    chk("R6 idle hold", acc_out, 40'd19879);

    // R7: drive a wrap with fractional -1*-1 terms
    issue(2'b01, 16'h8000, 16'h8000, 1'b1);
    for (int k = 0; k < 255; k++) issue(2'b10, 16'h8000, 16'h8000, 1'b1);
    chk("R7 no wrap yet", {39'h0, ovf_flag}, 40'h0);
    chk("R7 near max", acc_out, 40'h7F_FFFF_FF00);
    issue(2'b10, 16'h8000, 16'h8000, 1'b1);
    chk("R7 wrap value", acc_out, 40'h80_7FFF_FEFF);
    chk("R7 flag set", {39'h0, ovf_flag}, 40'h1);
    issue(2'b01, 16'd1, 16'd1, 1'b0);
    chk("R7 flag sticky", {39'h0, ovf_flag}, 40'h1);
    idle();
    @(negedge clk);
    chk("R6 flag hold", {39'h0, ovf_flag}, 40'h1);
    issue(2'b00, 16'h0, 16'h0, 1'b0);
    chk("R5 clear flag", {39'h0, ovf_flag}, 40'h0);
    idle();

    // R8 / R9 rounding
    issue(2'b01, 16'd6, 16'd16384, 1'b0); idle();          // 0x18000
    chk_res("R8 near 1.5", 1'b0, 1'b0, 16'h0002);
    chk_res("R9 conv 1.5", 1'b1, 1'b0, 16'h0002);
    issue(2'b01, 16'd2, 16'd16384, 1'b0); idle();          // 0x8000
    chk_res("R8 near 0.5", 1'b0, 1'b0, 16'h0001);
    chk_res("R9 conv 0.5", 1'b1, 1'b0, 16'h0000);
    issue(2'b01, 16'd5, 16'd19661, 1'b0); idle();          // 0x18001
    chk_res("R9 conv non-tie", 1'b1, 1'b0, 16'h0002);
    issue(2'b01, 16'hFFFA, 16'd16384, 1'b0); idle();       // -0x18000
    chk_res("R8 near -1.5", 1'b0, 1'b0, 16'hFFFF);
    chk_res("R9 conv -1.5", 1'b1, 1'b0, 16'hFFFE);

    // R10 saturation
    issue(2'b01, 16'h8000, 16'h8000, 1'b1); idle();        // 0x7FFFFFFF
    chk_res("R10 pos clamp", 1'b0, 1'b1, 16'h7FFF);
    chk_res("R10 pos raw", 1'b0, 1'b0, 16'h8000);
    issue(2'b00, 16'h0, 16'h0, 1'b0);
    issue(2'b11, 16'h8000, 16'h8000, 1'b1);
    issue(2'b11, 16'h4000, 16'h4000, 1'b1); idle();
    chk("R4 msu frac", acc_out, 40'hFF_6000_0001);
    chk_res("R10 neg clamp", 1'b0, 1'b1, 16'h8000);
    chk_res("R10 neg raw", 1'b0, 1'b0, 16'h6000);
    issue(2'b01, 16'h8000, 16'h7FFF, 1'b0); idle();        // 0xFFC0008000
    chk_res("R10 in range", 1'b0, 1'b1, 16'hC001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule